// File: doc/BRIEF.md
# Fetch/Execute Stage Sequencer

This block paces a serial stored-program machine through its two-phase instruction cycle. It keeps two mutually exclusive flags, a fetch flag and an execute flag. When a fetch starts, the block waits for the next digit-zero time and then sends one search pulse to the address-coincidence logic. When a coincidence is reported, the block moves to execute. It sends a start pulse to the execution control and, if the instruction needs a memory operand, sends a second search pulse at the next digit-zero time. Coincidences reported during execute are passed on as data-ready pulses.

When the execution control reports that it has finished, the block turns that end pulse into a sequence-counter increment unless the increment is held off. It then starts the next fetch, provided running is allowed. A separate flag, set by a jump-taken strobe and cleared at digit 18, enables the load of the instruction register into the sequence counter. The coincidence search, the memory, the arithmetic and the counter itself lie outside this block.

Top module: `fetch_exec_seq`

## Requirements
- R1: After synchronous reset all outputs are 0 and neither stage is active.
- R2: `fetch_o` and `exec_o` are never 1 together.
- R3: From idle, an end pulse or a step pulse sampled with `run_ok_i`=1 makes `fetch_o`=1 after that edge. With `run_ok_i`=0 both pulses are ignored and the block stays idle.
- R4: Entering fetch arms a search. The first `d0_i` sampled while armed gives `search_o`=1 for exactly the following cycle and disarms. Later `d0_i` pulses give no search.
- R5: `found_i` sampled during fetch sets `exec_o`=1, clears `fetch_o`, and gives a one-cycle `exec_start_o`, whether or not an operand is needed.
- R6: If `need_operand_i`=1 at that fetch-to-execute edge, the next sampled `d0_i` gives one more `search_o` pulse. If `need_operand_i`=0, no search follows.
- R7: `found_i` sampled during execute gives a one-cycle `data_ready_o`. `found_i` while idle has no effect.
- R8: An end pulse sampled during execute clears `exec_o` and gives a one-cycle `seq_inc_o` unless `inc_hold_i`=1. If `run_ok_i`=1 it also starts the next fetch; otherwise the block goes idle.
- R9: `jump_load_o` rises after a sampled `jump_taken_i` and falls after a sampled `d18_i`. When both are sampled in the same cycle, the flag is set.
- R10: An end pulse during fetch, and a step pulse during execute, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| end_pulse_i | input | 1 | Instruction-complete pulse from execution control |
| step_pulse_i | input | 1 | Manual single-step pulse |
| run_ok_i | input | 1 | Run permitted; low after a halt |
| d0_i | input | 1 | Digit-time 0 pulse |
| d18_i | input | 1 | Digit-time 18 pulse |
| found_i | input | 1 | Address coincidence found |
| need_operand_i | input | 1 | Decoded instruction needs a memory operand |
| jump_taken_i | input | 1 | Jump-taken strobe |
| inc_hold_i | input | 1 | Suppress the sequence increment (jump or I/O retry) |
| fetch_o | output | 1 | Fetch stage active |
| exec_o | output | 1 | Execute stage active |
| search_o | output | 1 | Search-stimulus pulse to coincidence logic |
| exec_start_o | output | 1 | Start pulse to execution control |
| data_ready_o | output | 1 | Operand-transferred pulse to execution control |
| seq_inc_o | output | 1 | Sequence-counter increment pulse |
| jump_load_o | output | 1 | Copy instruction register into sequence counter |

## Verification
The collision that matters is a coincidence report and an end pulse arriving in the same execute cycle. Both must take effect: a data-ready pulse and an increment appear in the same cycle, and the block goes back to fetch. The bench drives both inputs in one vector and expects both output pulses on the next cycle. A second collision, a jump strobe together with digit 18, is driven the same way, and the bench expects the jump-load flag to end up set.

// File: rtl/fes_pkg.sv
package fes_pkg;

    // events derived from inputs and current stage flags
    typedef struct packed {
        logic launch;   // begin a fetch
        logic end_ev;   // execute finished
        logic found_f;  // instruction located
        logic found_x;  // operand located
    } fes_ev_t;

    typedef struct packed {
        logic fetch;
        logic exec;
        logic arm;
    } fes_flags_t;

    typedef struct packed {
        logic search;
        logic start;
        logic drdy;
        logic inc;
    } fes_pulse_t;

    // set has priority over clear
    function automatic logic sr_next(input logic set, input logic clr, input logic q);
        return set ? 1'b1 : (clr ? 1'b0 : q);
    endfunction

endpackage

// File: rtl/fes_stage_flags.sv
module fes_stage_flags
    import fes_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       end_pulse,
    input  logic       step_pulse,
    input  logic       run_ok,
    input  logic       d0,
    input  logic       found,
    input  logic       need_operand,
    output fes_flags_t flags,
    output fes_ev_t    ev
);
    fes_flags_t q;
    logic idle;

    always_comb begin
        idle      = ~q.fetch & ~q.exec;
        ev.end_ev = end_pulse & q.exec;
        ev.launch = run_ok & (ev.end_ev | (idle & (end_pulse | step_pulse)));
        ev.found_f = found & q.fetch;
        ev.found_x = found & q.exec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.fetch <= sr_next(ev.launch, ev.found_f, q.fetch);
            q.exec  <= sr_next(ev.found_f, ev.end_ev, q.exec);
            q.arm   <= sr_next(ev.launch | (ev.found_f & need_operand), d0, q.arm);
        end
    end

    assign flags = q;
endmodule

// File: rtl/fes_pulse_gen.sv
module fes_pulse_gen
    import fes_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fes_ev_t    ev,
    input  logic       armed,
    input  logic       d0,
    input  logic       inc_hold,
    output fes_pulse_t pulses
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pulses <= '0;
        end else begin
            pulses.search <= armed & d0;
            pulses.start  <= ev.found_f;
            pulses.drdy   <= ev.found_x;
            pulses.inc    <= ev.end_ev & ~inc_hold;
        end
    end
endmodule

// File: rtl/fes_jump_window.sv
module fes_jump_window
    import fes_pkg::*;
#(
    parameter bit SET_WINS = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic jump_taken,
    input  logic d18,
    output logic load_en
);
    logic q;
    generate
        if (SET_WINS) begin : g_set_first
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b0;
                else     q <= sr_next(jump_taken, d18, q);
            end
        end else begin : g_clr_first
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b0;
                else     q <= d18 ? 1'b0 : (jump_taken | q);
            end
        end
    endgenerate
    assign load_en = q;
endmodule

// File: rtl/fetch_exec_seq.sv
module fetch_exec_seq
    import fes_pkg::*;
#(
    parameter bit JUMP_SET_WINS = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic end_pulse_i,
    input  logic step_pulse_i,
    input  logic run_ok_i,
    input  logic d0_i,
    input  logic d18_i,
    input  logic found_i,
    input  logic need_operand_i,
    input  logic jump_taken_i,
    input  logic inc_hold_i,
    output logic fetch_o,
    output logic exec_o,
    output logic search_o,
    output logic exec_start_o,
    output logic data_ready_o,
    output logic seq_inc_o,
    output logic jump_load_o
);
    fes_flags_t flags;
    fes_ev_t    ev;
    fes_pulse_t pulses;

    fes_stage_flags u_flags (
        .clk(clk), .rst(rst),
        .end_pulse(end_pulse_i), .step_pulse(step_pulse_i), .run_ok(run_ok_i),
        .d0(d0_i), .found(found_i), .need_operand(need_operand_i),
        .flags(flags), .ev(ev)
    );

    fes_pulse_gen u_pulses (
        .clk(clk), .rst(rst), .ev(ev), .armed(flags.arm), .d0(d0_i),
        .inc_hold(inc_hold_i), .pulses(pulses)
    );

    fes_jump_window #(.SET_WINS(JUMP_SET_WINS)) u_jump (
        .clk(clk), .rst(rst), .jump_taken(jump_taken_i), .d18(d18_i),
        .load_en(jump_load_o)
    );

    assign fetch_o      = flags.fetch;
    assign exec_o       = flags.exec;
    assign search_o     = pulses.search;
    assign exec_start_o = pulses.start;
    assign data_ready_o = pulses.drdy;
    assign seq_inc_o    = pulses.inc;
endmodule

// File: rtl/fes_checker.sv
module fes_checker (
    input logic clk,
    input logic rst,
    input logic end_pulse_i,
    input logic step_pulse_i,
    input logic run_ok_i,
    input logic d0_i,
    input logic d18_i,
    input logic found_i,
    input logic need_operand_i,
    input logic jump_taken_i,
    input logic inc_hold_i,
    input logic fetch_o,
    input logic exec_o,
    input logic search_o,
    input logic exec_start_o,
    input logic data_ready_o,
    input logic seq_inc_o,
    input logic jump_load_o
);
    assert_stage_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(fetch_o && exec_o));

    assert_halt_blocks_R3: assert property (@(posedge clk) disable iff (rst)
        (!run_ok_i && !fetch_o && !exec_o) |=> (!fetch_o && !exec_o));

    assert_search_after_d0_R4: assert property (@(posedge clk) disable iff (rst)
        search_o |-> $past(d0_i));

    assert_search_single_R4: assert property (@(posedge clk) disable iff (rst)
        search_o |=> !search_o);

    assert_enter_exec_R5: assert property (@(posedge clk) disable iff (rst)
        (found_i && fetch_o) |=> (exec_o && !fetch_o && exec_start_o));

    assert_data_ready_R7: assert property (@(posedge clk) disable iff (rst)
        (found_i && exec_o) |=> data_ready_o);

    assert_inc_R8: assert property (@(posedge clk) disable iff (rst)
        (end_pulse_i && exec_o && !inc_hold_i) |=> (seq_inc_o && !exec_o));

    assert_inc_held_R8: assert property (@(posedge clk) disable iff (rst)
        inc_hold_i |=> !seq_inc_o);

    assert_jump_set_R9: assert property (@(posedge clk) disable iff (rst)
        jump_taken_i |=> jump_load_o);

    assert_jump_clr_R9: assert property (@(posedge clk) disable iff (rst)
        (d18_i && !jump_taken_i) |=> !jump_load_o);
endmodule

bind fetch_exec_seq fes_checker u_fes_checker (.*);

// File: tb/test_fetch_exec_seq.sv
module test_fetch_exec_seq;
    logic clk = 1'b0;
    logic rst;
    logic end_p, step_p, run_ok, d0, d18, found, need, jump, hold;
    logic fetch_o, exec_o, search_o, exec_start_o, data_ready_o, seq_inc_o, jump_load_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    fetch_exec_seq i_fetch_exec_seq (
        .clk(clk), .rst(rst),
        .end_pulse_i(end_p), .step_pulse_i(step_p), .run_ok_i(run_ok),
        .d0_i(d0), .d18_i(d18), .found_i(found), .need_operand_i(need),
        .jump_taken_i(jump), .inc_hold_i(hold),
        .fetch_o(fetch_o), .exec_o(exec_o), .search_o(search_o),
        .exec_start_o(exec_start_o), .data_ready_o(data_ready_o),
        .seq_inc_o(seq_inc_o), .jump_load_o(jump_load_o)
    );

    // vector: req[20:17], inputs {run,end,step,d0,d18,found,need,jump,hold} [16:8],
    // expected {fetch,exec,search,start,drdy,inc,jload} [6:0]; bit 7 unused
    localparam int NV = 28;
    localparam logic [20:0] VEC [NV] = '{
        {4'd3,  9'b101000000, 1'b0, 7'b1000000}, // R3 step from idle
        {4'd4,  9'b100000000, 1'b0, 7'b1000000}, // R4 waiting for D0
        {4'd4,  9'b100100000, 1'b0, 7'b1010000}, // R4 search
        {4'd4,  9'b100100000, 1'b0, 7'b1000000}, // R4 no second search
        {4'd5,  9'b100001100, 1'b0, 7'b0101000}, // R5 enter exec, operand needed
        {4'd6,  9'b100100000, 1'b0, 7'b0110000}, // R6 operand search
        {4'd7,  9'b100001000, 1'b0, 7'b0100100}, // R7 data ready
        {4'd8,  9'b110000000, 1'b0, 7'b1000010}, // R8 increment, next fetch
        {4'd4,  9'b100100000, 1'b0, 7'b1010000}, // R4
        {4'd5,  9'b100001000, 1'b0, 7'b0101000}, // R5 no operand
        {4'd6,  9'b100100000, 1'b0, 7'b0100000}, // R6 no operand search
        {4'd9,  9'b100000010, 1'b0, 7'b0100001}, // R9 set
        {4'd9,  9'b100000000, 1'b0, 7'b0100001}, // R9 hold
        {4'd9,  9'b100010000, 1'b0, 7'b0100000}, // R9 clear at D18
        {4'd8,  9'b110000001, 1'b0, 7'b1000000}, // R8 increment held
        {4'd4,  9'b100100000, 1'b0, 7'b1010000}, // R4
        {4'd5,  9'b100001000, 1'b0, 7'b0101000}, // R5
        {4'd7,  9'b110001000, 1'b0, 7'b1000110}, // R7 and R8 together
        {4'd10, 9'b110000000, 1'b0, 7'b1000000}, // R10 end during fetch
        {4'd4,  9'b100100000, 1'b0, 7'b1010000}, // R4 still armed
        {4'd5,  9'b100001000, 1'b0, 7'b0101000}, // R5
        {4'd10, 9'b101000000, 1'b0, 7'b0100000}, // R10 step during exec
        {4'd9,  9'b100010010, 1'b0, 7'b0100001}, // R9 collision, set wins
        {4'd9,  9'b100010000, 1'b0, 7'b0100000}, // R9
        {4'd8,  9'b010000000, 1'b0, 7'b0000010}, // R8 end with run low -> idle
        {4'd3,  9'b001000000, 1'b0, 7'b0000000}, // R3 step blocked
        {4'd7,  9'b000001000, 1'b0, 7'b0000000}, // R7 found in idle ignored
        {4'd3,  9'b110000000, 1'b0, 7'b1000000}  // R3 end from idle
    };

    function automatic logic [6:0] outs();
        return {fetch_o, exec_o, search_o, exec_start_o, data_ready_o, seq_inc_o, jump_load_o};
    endfunction

    task automatic check(input int req, input logic [6:0] exp);
        checks++;
        if (outs() !== exp) begin
            fails++;
            $display("FAIL R%0d: got %b expected %b", req, outs(), exp);
        end
    endtask

    task automatic drive(input logic [8:0] v);
        {run_ok, end_p, step_p, d0, d18, found, need, jump, hold} = v;
    endtask

    initial begin
        drive(9'b0);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(1, 7'b0000000); // R1 reset state
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][16:8]);
            @(negedge clk);
            check(int'(VEC[i][20:17]), VEC[i][6:0]);
        end
        // R1: reset mid-run clears everything
        drive(9'b100000010);
        @(negedge clk);
        rst = 1'b1;
        drive(9'b0);
        @(negedge clk);
        check(1, 7'b0000000);
        rst = 1'b0;
        @(negedge clk);
        check(1, 7'b0000000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule